// File: doc/BRIEF.md
# Multicore CPU Release Controller

This block is a small memory-mapped configuration unit for a cluster of four processor cores. It sits on a simple 32-bit register bus with a 1 KiB address window. It holds three software-visible storage words: the boot entry address, a general control word and a standby flag. The remaining decoded locations return fixed status values, or are placeholders that read zero.

Boot firmware running on the primary core releases a secondary core in two steps. It first writes the entry address. It then writes any nonzero value to that core's reset-control word. The block turns this write into a one-cycle start request. The request carries the core index, the entry address latched at that moment and a fixed boot privilege level of 3. Power sequencing, clock gating, the free-running counter and the debug word are handled elsewhere. Their locations are decoded here but have no function.

Top module: `core_release_ctrl`

## Requirements
- R1: After the active-low synchronous reset, the entry address reads 0, the general control word reads 0x20 and the standby flag reads 0. In the same state `boot_valid`, `bus_err` and `bus_rdata` are all 0.
- R2: Three words read back the last full-word write: entry address at 0x1A4, general control at 0x184 and standby flag at 0x1A0.
- R3: Some words have fixed values. Offsets 0x000 and 0x140 read 0x1. The clock-gating word at 0x144 reads 0x10F. Each core n has a group at 0x40 + 0x40·n: the reset-control word (+0) reads 0x3, the control word (+4) reads 0 and the status word (+8) reads 0x1. Writes to any of these words change no readable value.
- R4: Offsets 0x1E4, 0x280, 0x284 and 0x288 are decoded placeholders. They read 0, ignore writes and raise no error.
- R5: A full-word write of a nonzero value to core n's reset-control word at 0x40 + 0x40·n makes `boot_valid` high for exactly the next cycle. In that cycle `boot_core` = n, `boot_el` = 3 and `boot_addr` equals the entry address held when the write was accepted.
- R6: A write of zero to a reset-control word produces no start request. Writes to any other offset produce no start request either.
- R7: An entry address written in the bus cycle just before a trigger write is the address carried by that trigger's request.
- R8: Read data appears on `bus_rdata` in the cycle after the read strobe. In every cycle that does not follow a read strobe, `bus_rdata` is 0.
- R9: An access to an undecoded word offset inside the window has these effects: a read returns 0, a write changes nothing, and `bus_err` is high for the one cycle after the strobe. Decoded offsets never raise `bus_err`.
- R10: Only 32-bit accesses are valid. An access whose byte enables are not all 4'hF is treated as undecoded: it reads 0, changes nothing, fires no request and raises `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | 10 | Byte offset within the window |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, one cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle pulse after an undecoded or partial access |
| boot_valid | output | 1 | One-cycle start request |
| boot_core | output | 2 | Index of the core to release |
| boot_addr | output | 32 | Entry address for the released core |
| boot_el | output | 2 | Privilege level at boot, always 3 |

## Verification
The embedded assertions check several rules on every cycle:
- each start request is traced back to an accepted nonzero trigger write in the cycle before;
- a zero write never fires a request;
- a request carries the previous cycle's entry address and level 3;
- a stored word takes the data of the write that targets it;
- `bus_err` and `bus_rdata` are only active after a strobe.

Other properties depend on the whole address map, so only the bench scenarios can show them. These include the fixed read value of each offset, the error decode of undecoded offsets, the sweep that writes to every word and then reads every word back, the back-to-back entry-then-trigger ordering, partial byte enables and a mid-run reset.

// File: rtl/crc_pkg.sv
// Shared types and constants for the core release controller.
// Assumes a byte-addressed window with word-aligned register offsets.
package crc_pkg;
    typedef enum logic [3:0] {
        RG_NONE,
        RG_CLUSTER_RST,
        RG_SYS_RST,
        RG_CORE_RST,
        RG_CORE_CTRL,
        RG_CORE_STAT,
        RG_CLKGATE,
        RG_GENCTRL,
        RG_STANDBY,
        RG_ENTRY,
        RG_PLACEHOLDER
    } region_e;

    localparam int OFF_CLUSTER_RST = 'h000;
    localparam int OFF_CORE_BASE   = 'h040;
    localparam int CORE_STRIDE_LG  = 6;
    localparam int OFF_SYS_RST     = 'h140;
    localparam int OFF_CLKGATE     = 'h144;
    localparam int OFF_GENCTRL     = 'h184;
    localparam int OFF_STANDBY     = 'h1A0;
    localparam int OFF_ENTRY       = 'h1A4;
    localparam int OFF_DEBUG       = 'h1E4;
    localparam int OFF_CNT_CTRL    = 'h280;
    localparam int OFF_CNT_LO      = 'h284;
    localparam int OFF_CNT_HI      = 'h288;

    localparam logic [31:0] GENCTRL_INIT  = 32'h0000_0020;
    localparam logic [31:0] CLKGATE_VAL   = 32'h0000_010F;
    localparam logic [31:0] CORE_RST_VAL  = 32'h0000_0003;
    localparam logic [31:0] RELEASED_VAL  = 32'h0000_0001;
    localparam logic [1:0]  BOOT_LEVEL    = 2'd3;
endpackage

// File: rtl/crc_decode.sv
// Address decoder: maps a bus offset and its byte enables to a register region and a core index.
// Assumes: the per-core groups do not overlap the fixed offsets (holds for NUM_CORES <= 4).
module crc_decode
    import crc_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output region_e           region,
    output logic [IDX_W-1:0]  core_idx
);
    localparam int CORE_END = OFF_CORE_BASE + (NUM_CORES << CORE_STRIDE_LG);

    int off;
    int rel;

    // Classify the access; partial or misaligned accesses decode to RG_NONE.
    always_comb begin
        off      = int'(addr);
        rel      = off - OFF_CORE_BASE;
        region   = RG_NONE;
        core_idx = '0;
        if (be == 4'hF && addr[1:0] == 2'b00) begin
            if (off == OFF_CLUSTER_RST)      region = RG_CLUSTER_RST;
            else if (off == OFF_SYS_RST)     region = RG_SYS_RST;
            else if (off == OFF_CLKGATE)     region = RG_CLKGATE;
            else if (off == OFF_GENCTRL)     region = RG_GENCTRL;
            else if (off == OFF_STANDBY)     region = RG_STANDBY;
            else if (off == OFF_ENTRY)       region = RG_ENTRY;
            else if (off == OFF_DEBUG || off == OFF_CNT_CTRL ||
                     off == OFF_CNT_LO || off == OFF_CNT_HI)
                                             region = RG_PLACEHOLDER;
            else if (off >= OFF_CORE_BASE && off < CORE_END) begin
                core_idx = IDX_W'(rel >> CORE_STRIDE_LG);
                case (rel & 'h3F)
                    0:       region = RG_CORE_RST;
                    4:       region = RG_CORE_CTRL;
                    8:       region = RG_CORE_STAT;
                    default: region = RG_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/crc_regfile.sv
// Storage for the three writable words: entry address, general control and standby flag.
// Assumes: writes arrive as a one-cycle strobe with an already-decoded region.
module crc_regfile
    import crc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  region_e           region,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] entry_q,
    output logic [DATA_W-1:0] genctrl_q,
    output logic [DATA_W-1:0] standby_q
);
    // Update the addressed word on a write strobe; reset loads initial values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q   <= '0;
            genctrl_q <= DATA_W'(GENCTRL_INIT);
            standby_q <= '0;
        end else if (wr) begin
            if (region == RG_ENTRY)   entry_q   <= wdata;
            if (region == RG_GENCTRL) genctrl_q <= wdata;
            if (region == RG_STANDBY) standby_q <= wdata;
        end
    end

    a_r1_reset_values: assert property (@(posedge clk)
        !rst_n |=> (entry_q == '0 && standby_q == '0 && genctrl_q == DATA_W'(GENCTRL_INIT)));
    a_r2_entry_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_ENTRY) |=> entry_q == $past(wdata));
    a_r2_entry_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && region == RG_ENTRY) |=> $stable(entry_q));
endmodule

// File: rtl/crc_launch.sv
// Start-request generator: a nonzero write to a reset-control word emits a one-cycle request.
// Assumes: entry_q is the registered entry address, so the value before this edge is carried.
module crc_launch
    import crc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  region_e           region,
    input  logic [IDX_W-1:0]  core_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] entry_q,
    output logic              boot_valid,
    output logic [IDX_W-1:0]  boot_core,
    output logic [DATA_W-1:0] boot_addr,
    output logic [1:0]        boot_el
);
    logic fire;

    // A trigger is a write to a reset-control word with any bit set.
    always_comb fire = wr && region == RG_CORE_RST && wdata != '0;

    // Register the request for one cycle, capturing the index and the current entry address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_valid <= 1'b0;
            boot_core  <= '0;
            boot_addr  <= '0;
        end else begin
            boot_valid <= fire;
            if (fire) begin
                boot_core <= core_idx;
                boot_addr <= entry_q;
            end
        end
    end

    assign boot_el = BOOT_LEVEL;

    a_r5_request_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        boot_valid |-> $past(wr && region == RG_CORE_RST && wdata != '0));
    a_r5_request_core: assert property (@(posedge clk) disable iff (!rst_n)
        boot_valid |-> boot_core == $past(core_idx));
    a_r5_request_level: assert property (@(posedge clk) disable iff (!rst_n)
        boot_valid |-> boot_el == 2'd3);
    a_r6_zero_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_CORE_RST && wdata == '0) |=> !boot_valid);
    a_r7_addr_from_entry: assert property (@(posedge clk) disable iff (!rst_n)
        boot_valid |-> boot_addr == $past(entry_q));
endmodule

// File: rtl/core_release_ctrl.sv
// Core release controller top: register bus front end, registered read path and error pulse.
// Assumes: single-cycle strobes, 32-bit data, a 1 KiB window; read and write may share a cycle
// (the read then returns the value from before the write).
module core_release_ctrl
    import crc_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int NUM_CORES = 4,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              boot_valid,
    output logic [IDX_W-1:0]  boot_core,
    output logic [DATA_W-1:0] boot_addr,
    output logic [1:0]        boot_el
);
    region_e           region;
    logic [IDX_W-1:0]  core_idx;
    logic [DATA_W-1:0] entry_q, genctrl_q, standby_q;
    logic [DATA_W-1:0] rd_val;

    crc_decode #(.ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_decode (
        .addr(bus_addr), .be(bus_be), .region(region), .core_idx(core_idx)
    );

    crc_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .region(region), .wdata(bus_wdata),
        .entry_q(entry_q), .genctrl_q(genctrl_q), .standby_q(standby_q)
    );

    crc_launch #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_launch (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .region(region), .core_idx(core_idx),
        .wdata(bus_wdata), .entry_q(entry_q), .boot_valid(boot_valid),
        .boot_core(boot_core), .boot_addr(boot_addr), .boot_el(boot_el)
    );

    // Select the read value for the decoded region.
    always_comb begin
        case (region)
            RG_CLUSTER_RST, RG_SYS_RST, RG_CORE_STAT: rd_val = DATA_W'(RELEASED_VAL);
            RG_CORE_RST:  rd_val = DATA_W'(CORE_RST_VAL);
            RG_CLKGATE:   rd_val = DATA_W'(CLKGATE_VAL);
            RG_GENCTRL:   rd_val = genctrl_q;
            RG_STANDBY:   rd_val = standby_q;
            RG_ENTRY:     rd_val = entry_q;
            default:      rd_val = '0;
        endcase
    end

    // Register the read data and the access error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= bus_rd ? rd_val : '0;
            bus_err   <= (bus_rd || bus_wr) && region == RG_NONE;
        end
    end

    a_r8_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);
    a_r9_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd || bus_wr));
    a_r10_partial_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_be != 4'hF) |=> bus_err);
endmodule

// File: tb/core_release_ctrl_tb.sv
// Self-checking bench: sweeps every word offset with reads and writes against an arithmetic model.
module core_release_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        boot_valid;
    logic [1:0]  boot_core;
    logic [31:0] boot_addr;
    logic [1:0]  boot_el;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_gen = 32'h20, m_stby = 0, m_entry = 0;

    always #4 clk = ~clk;

    core_release_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .boot_valid(boot_valid), .boot_core(boot_core), .boot_addr(boot_addr), .boot_el(boot_el)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic bit is_core_grp(input int a);
        return a >= 'h40 && a < 'h140;
    endfunction

    function automatic bit decoded(input int a);
        if (is_core_grp(a)) return (a % 64) == 0 || (a % 64) == 4 || (a % 64) == 8;
        return a == 0 || a == 'h140 || a == 'h144 || a == 'h184 || a == 'h1A0 ||
               a == 'h1A4 || a == 'h1E4 || a == 'h280 || a == 'h284 || a == 'h288;
    endfunction

    function automatic logic [31:0] exp_rd(input int a);
        if (a == 0 || a == 'h140) return 1;
        if (is_core_grp(a)) begin
            if (a % 64 == 0) return 3;
            if (a % 64 == 8) return 1;
            return 0;
        end
        if (a == 'h144) return 32'h10F;
        if (a == 'h184) return m_gen;
        if (a == 'h1A0) return m_stby;
        if (a == 'h1A4) return m_entry;
        return 0;
    endfunction

    // Read one offset; outputs are checked at the following falling edge.
    task automatic do_read(input int a, input logic [3:0] be, input string req);
        @(negedge clk);
        bus_rd = 1; bus_addr = 10'(a); bus_be = be;
        @(negedge clk);
        bus_rd = 0; bus_be = 4'hF;
        chk(req, bus_rdata, (be == 4'hF) ? exp_rd(a) : 32'h0);
        chk({req, " err"}, 32'(bus_err), 32'((be != 4'hF) || !decoded(a)));
    endtask

    // Write one offset and check the request and error outputs one cycle later.
    task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] be, input string req);
        bit full = (be == 4'hF);
        bit trig = full && is_core_grp(a) && (a % 64 == 0) && d != 0;
        logic [31:0] prev_entry = m_entry;
        @(negedge clk);
        bus_wr = 1; bus_addr = 10'(a); bus_wdata = d; bus_be = be;
        if (full && a == 'h184) m_gen = d;
        if (full && a == 'h1A0) m_stby = d;
        if (full && a == 'h1A4) m_entry = d;
        @(negedge clk);
        bus_wr = 0; bus_be = 4'hF;
        chk({req, " valid"}, 32'(boot_valid), 32'(trig));
        if (trig) begin
            chk({req, " core"}, 32'(boot_core), 32'((a - 'h40) >> 6));
            chk({req, " addr"}, boot_addr, prev_entry);
            chk({req, " el"}, 32'(boot_el), 32'd3);
        end
        chk({req, " err"}, 32'(bus_err), 32'(!full || !decoded(a)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle outputs in reset state
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 valid", 32'(boot_valid), 0);
        chk("R1 err", 32'(bus_err), 0);
        rst_n = 1;
        // R1 R3 R4 R9: read sweep of every word offset after reset
        for (int a = 0; a < 1024; a += 4) do_read(a, 4'hF, "R1/R3/R4/R9 read");
        // R8: no strobe gives zero data
        @(negedge clk); chk("R8 idle rdata", bus_rdata, 0);
        // R2 R3 R4 R5 R6 R9: write every offset with a nonzero pattern, then reread
        for (int a = 0; a < 1024; a += 4) begin
            if (a == 'h1A4) do_write(a, 32'h8000_0000 | 32'(a), 4'hF, "R2 entry write");
            else do_write(a, 32'hA500_0000 ^ 32'(a), 4'hF, "R5/R6 sweep write");
        end
        for (int a = 0; a < 1024; a += 4) do_read(a, 4'hF, "R2/R3/R4 reread");
        // R5 R7: entry written just before each trigger
        for (int n = 0; n < 4; n++) begin
            do_write('h1A4, 32'h1000_0000 + 32'(n * 'h111), 4'hF, "R7 entry");
            do_write('h40 + 64 * n, 32'(n + 1), 4'hF, "R5/R7 trigger");
        end
        // R6: zero writes fire nothing
        for (int n = 0; n < 4; n++) do_write('h40 + 64 * n, 0, 4'hF, "R6 zero write");
        // R10: partial accesses
        do_write('h1A4, 32'hDEAD_BEEF, 4'h3, "R10 partial write");
        do_write('h40, 32'h1, 4'h1, "R10 partial trigger");
        do_read('h1A4, 4'h7, "R10 partial read");
        do_read('h1A4, 4'hF, "R10 entry unchanged");
        // R1: reset in mid-run restores the initial values
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        m_gen = 32'h20; m_stby = 0; m_entry = 0;
        do_read('h184, 4'hF, "R1 genctrl");
        do_read('h1A0, 4'hF, "R1 standby");
        do_read('h1A4, 4'hF, "R1 entry");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule